// File: doc/BRIEF.md
# SPI ADC Conversion Sequencer

This block is a synchronous SPI master for a two-input, 10-bit successive-approximation converter. A start request carries an input-select bit and a pseudo-differential flag. For each request the block lowers chip select and shifts a four-bit command out on the data line. It then drives a frame of exactly sixteen serial clocks, divided down from the system clock. From the returned stream it drops the leading null bit, gathers the ten result bits MSB first, and presents the code with a one-cycle valid strobe. The strobe carries tags naming the input and the mode that produced the code.

All interface timing is counted in system-clock cycles and set by parameters: the half period of the serial clock, the chip-select setup before the first rising edge, and the minimum deselect time between frames. A start that arrives while a frame or a deselect interval is in progress is held. It is launched in the cycle that the deselect interval ends. While the continuous input is high, frames follow each other back to back with the last command, and each pair is separated by exactly the deselect interval. A parameter selects clock polarity, giving SPI mode 0 or mode 3. In both modes the converter takes data on rising edges and drives data after falling edges.

Top module: `spi_adc_seq`

## Requirements
- R1: After reset, cs_no is 1, sclk_o rests at CLK_POL, result_valid_o is 0 and busy_o is 0.
- R2: While cs_no is 1, sclk_o stays at CLK_POL (0 for mode 0, 1 for mode 3). Within a frame, once chip select has been low for a cycle, mosi_o does not change while sclk_o stays high.
- R3: Each frame has exactly 16 rising sclk_o edges while cs_no is 0. Every high phase and every low phase lasts at least HALF_CYC system cycles.
- R4: mosi_o presents four command bits, one sampled at each of rising edges 1 to 4 in this order: 1 (start), single-ended flag (1 when diff_i=0, 0 when diff_i=1), chan_i, 1 (MSB-first). mosi_o is 0 at rising edges 5 to 16.
- R5: The miso_i bit before rising edge 5 is discarded, whatever its value. The bits before rising edges 6 to 15 become result_o[9] down to result_o[0], in straight binary. All 1024 codes pass unchanged.
- R6: result_valid_o is a pulse exactly one cycle long, raised while cs_no is 1. It carries result_o together with result_chan_o and result_diff_o, which equal the chan_i and diff_i of the request that started the frame.
- R7: From the falling edge of cs_no to the first rising edge of sclk_o, at least CS_SETUP_CYC system cycles pass.
- R8: Between two frames, cs_no stays high for at least CS_HIGH_CYC system cycles.
- R9: A start_i pulse that arrives while busy is held. The frame it requests begins exactly CS_HIGH_CYC cycles after chip select rises, and that frame carries the held request's chan_i and diff_i.
- R10: While cont_i is 1, frames repeat with the last launched command, and cs_no is high for exactly CS_HIGH_CYC cycles between them. Once cont_i returns to 0, no new frame starts after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle conversion request |
| chan_i | input | 1 | Input select; in pseudo-differential mode, the polarity select |
| diff_i | input | 1 | 1 selects pseudo-differential, 0 selects single-ended |
| cont_i | input | 1 | Repeat the last command back to back while high |
| busy_o | output | 1 | A frame or deselect interval is in progress |
| cs_no | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Command data to the converter |
| miso_i | input | 1 | Result data from the converter |
| result_o | output | 10 | Conversion code |
| result_chan_o | output | 1 | Input-select tag of result_o |
| result_diff_o | output | 1 | Mode tag of result_o |
| result_valid_o | output | 1 | One-cycle result strobe |

## Verification
Two events can fall in the same cycle. The first is the end of the deselect interval. The second is the launch of the next frame, either from a held start or from the continuous input. The bench provokes this by pulsing a second start in the middle of a running frame, and by holding the continuous input through a full 1024-frame sweep. It judges the result by measuring the chip-select high time: it must equal the deselect count exactly, never fall below it, and never exceed it. Each frame must also carry the requested tags. Separately, the result strobe coincides with the rising edge of chip select, and the bench checks that it appears only while chip select is high.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;
  localparam int unsigned FRAME_CLKS = 16;
  localparam int unsigned CMD_W      = 4;
  localparam int unsigned RES_W      = 10;
  localparam int unsigned BIT_W      = $clog2(FRAME_CLKS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_TAIL, ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic chan;
    logic diff;
  } conv_req_t;

  // start, single-ended flag, select, msb-first
  function automatic logic [CMD_W-1:0] build_cmd(conv_req_t r);
    return {1'b1, ~r.diff, r.chan, 1'b1};
  endfunction
endpackage

// File: rtl/spi_adc_req_hold.sv
module spi_adc_req_hold
  import spi_adc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  conv_req_t req_i,
  input  logic      cont_i,
  input  logic      ready_i,
  output logic      launch_o,
  output conv_req_t req_o
);
  logic      pend_q;
  conv_req_t pend_req_q;
  conv_req_t last_q;

  always_comb begin
    launch_o = ready_i & (pend_q | start_i | cont_i);
    if (pend_q)       req_o = pend_req_q;
    else if (start_i) req_o = req_i;
    else              req_o = last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_req_q <= '0;
      last_q     <= '0;
    end else begin
      if (launch_o) begin
        last_q <= req_o;
        pend_q <= pend_q & start_i;
        if (pend_q & start_i) pend_req_q <= req_i;
      end else if (start_i) begin
        pend_q     <= 1'b1;
        pend_req_q <= req_i;
      end
    end
  end

  a_r9_start_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !ready_i) |=> pend_q);
  a_r9_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ready_i) |=> pend_q);
endmodule

// File: rtl/spi_adc_timer.sv
module spi_adc_timer
  import spi_adc_pkg::*;
#(
  parameter int unsigned HALF_CYC     = 14,
  parameter int unsigned CS_SETUP_CYC = 10,
  parameter int unsigned CS_HIGH_CYC  = 31,
  parameter int unsigned CLK_POL      = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  output logic             ready_o,
  output logic             busy_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             done_o,
  output logic [BIT_W-1:0] bit_o
);
  localparam int unsigned MAX_AB = (HALF_CYC > CS_SETUP_CYC) ? HALF_CYC : CS_SETUP_CYC;
  localparam int unsigned MAX_C  = (MAX_AB > CS_HIGH_CYC) ? MAX_AB : CS_HIGH_CYC;
  localparam int unsigned CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(CS_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(CS_HIGH_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_CLKS - 1);

  logic idle_lvl;
  if (CLK_POL != 0) begin : g_mode3
    assign idle_lvl = 1'b1;
  end else begin : g_mode0
    assign idle_lvl = 1'b0;
  end

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             cnt_zero;
  logic             cs_n_q, sclk_q;
  logic             active_d;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    bit_d   = bit_q;
    unique case (state_q)
      ST_IDLE: if (launch_i) begin
        state_d = ST_SETUP;
        cnt_d   = SETUP_LD;
      end
      ST_SETUP: if (cnt_zero) begin
        state_d = ST_LOW;
        cnt_d   = HALF_LD;
        bit_d   = '0;
      end
      ST_LOW: if (cnt_zero) begin
        state_d = ST_HIGH;
        cnt_d   = HALF_LD;
      end
      ST_HIGH: if (cnt_zero) begin
        cnt_d = HALF_LD;
        if (bit_q == LAST_BIT) state_d = ST_TAIL;
        else begin
          state_d = ST_LOW;
          bit_d   = bit_q + 1'b1;
        end
      end
      ST_TAIL: if (cnt_zero) begin
        state_d = ST_GAP;
        cnt_d   = GAP_LD;
      end
      ST_GAP: if (cnt_zero) begin
        if (launch_i) begin
          state_d = ST_SETUP;
          cnt_d   = SETUP_LD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign active_d = (state_d == ST_SETUP) || (state_d == ST_LOW) ||
                    (state_d == ST_HIGH)  || (state_d == ST_TAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= idle_lvl;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      cs_n_q  <= ~active_d;
      if (state_d == ST_HIGH)     sclk_q <= 1'b1;
      else if (state_d == ST_LOW) sclk_q <= 1'b0;
      else                        sclk_q <= idle_lvl;
    end
  end

  assign ready_o  = (state_q == ST_IDLE) || ((state_q == ST_GAP) && cnt_zero);
  assign busy_o   = (state_q != ST_IDLE);
  assign sample_o = (state_q == ST_HIGH) && cnt_zero;
  assign shift_o  = sample_o && (bit_q != LAST_BIT);
  assign done_o   = (state_q == ST_TAIL) && cnt_zero;
  assign bit_o    = bit_q;
  assign cs_no    = cs_n_q;
  assign sclk_o   = sclk_q;

  a_r2_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (sclk_o == idle_lvl));
  a_r7_no_edge_at_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (sclk_o == idle_lvl));
  a_r8_done_deselects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cs_no);
endmodule

// File: rtl/spi_adc_shift.sv
module spi_adc_shift
  import spi_adc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  conv_req_t        req_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             done_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [RES_W-1:0] result_o,
  output logic             chan_o,
  output logic             diff_o,
  output logic             valid_o
);
  localparam logic [BIT_W-1:0] FIRST_DATA = BIT_W'(CMD_W + 1);
  localparam logic [BIT_W-1:0] LAST_DATA  = BIT_W'(CMD_W + RES_W);

  logic [CMD_W-1:0] tx_q;
  logic [RES_W-1:0] rx_q;
  conv_req_t        tag_q;
  logic             in_data;

  // bit CMD_W is the null bit: outside the window, never shifted in
  assign in_data = (bit_i >= FIRST_DATA) && (bit_i <= LAST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '0;
      rx_q     <= '0;
      tag_q    <= '0;
      result_o <= '0;
      chan_o   <= 1'b0;
      diff_o   <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      if (load_i) begin
        tx_q  <= build_cmd(req_i);
        tag_q <= req_i;
      end else if (shift_i) begin
        tx_q <= {tx_q[CMD_W-2:0], 1'b0};
      end
      if (sample_i && in_data) rx_q <= {rx_q[RES_W-2:0], miso_i};
      valid_o <= done_i;
      if (done_i) begin
        result_o <= rx_q;
        chan_o   <= tag_q.chan;
        diff_o   <= tag_q.diff;
      end
    end
  end

  assign mosi_o = tx_q[CMD_W-1];

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/spi_adc_seq.sv
module spi_adc_seq
  import spi_adc_pkg::*;
#(
  parameter int unsigned HALF_CYC     = 14,
  parameter int unsigned CS_SETUP_CYC = 10,
  parameter int unsigned CS_HIGH_CYC  = 31,
  parameter int unsigned CLK_POL      = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             chan_i,
  input  logic             diff_i,
  input  logic             cont_i,
  output logic             busy_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [RES_W-1:0] result_o,
  output logic             result_chan_o,
  output logic             result_diff_o,
  output logic             result_valid_o
);
  localparam int unsigned GAP_W = $clog2(CS_HIGH_CYC + 1);

  conv_req_t        in_req, run_req;
  logic             ready, launch;
  logic             shift, sample, done;
  logic [BIT_W-1:0] bit_idx;

  assign in_req = '{chan: chan_i, diff: diff_i};

  spi_adc_req_hold u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .req_i   (in_req),
    .cont_i  (cont_i),
    .ready_i (ready),
    .launch_o(launch),
    .req_o   (run_req)
  );

  spi_adc_timer #(
    .HALF_CYC    (HALF_CYC),
    .CS_SETUP_CYC(CS_SETUP_CYC),
    .CS_HIGH_CYC (CS_HIGH_CYC),
    .CLK_POL     (CLK_POL)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .ready_o (ready),
    .busy_o  (busy_o),
    .cs_no   (cs_no),
    .sclk_o  (sclk_o),
    .shift_o (shift),
    .sample_o(sample),
    .done_o  (done),
    .bit_o   (bit_idx)
  );

  spi_adc_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (launch),
    .req_i   (run_req),
    .shift_i (shift),
    .sample_i(sample),
    .bit_i   (bit_idx),
    .done_i  (done),
    .miso_i  (miso_i),
    .mosi_o  (mosi_o),
    .result_o(result_o),
    .chan_o  (result_chan_o),
    .diff_o  (result_diff_o),
    .valid_o (result_valid_o)
  );

  // deselect run length, saturating; reset counts as a long deselect
  logic [GAP_W-1:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  hi_run_q <= GAP_W'(CS_HIGH_CYC);
    else if (!cs_no)                              hi_run_q <= '0;
    else if (hi_run_q != GAP_W'(CS_HIGH_CYC))     hi_run_q <= hi_run_q + 1'b1;
  end

  a_r8_deselect_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_run_q == GAP_W'(CS_HIGH_CYC)));
  a_r6_valid_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> cs_no);
  a_r2_data_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$past(cs_no) && sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
endmodule

// File: tb/spi_adc_seq_tb_side.sv
module spi_adc_seq_tb_side #(
  parameter int CPOL  = 0,
  parameter int HALF  = 2,
  parameter int SETUP = 3,
  parameter int GAP   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  output logic       miso,
  input  logic [9:0] result,
  input  logic       rchan,
  input  logic       rdiff,
  input  logic       rvalid
);
  localparam int STEP = 37;
  localparam int OFF  = 300;

  int checks = 0, fails = 0, nvalid = 0, fno = 0;
  int rises = 0, hi_cnt = 0, since_fall = 0, run = 0, last_gap = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0, prev_valid = 1'b0;
  logic seen = 1'b0, tail_bad = 1'b0, moved = 1'b0;
  logic [3:0] cmd = '0;
  logic [9:0] code = '0;
  logic last_chan = 1'b0, last_diff = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s mode%0d act=%0d exp=%0d t=%0t", req, CPOL, act, exp, $time);
    end
  endtask

  initial miso = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = CPOL[0]; prev_valid = 1'b0;
      miso <= 1'b0;
    end else begin
      if (rvalid) begin
        nvalid++;
        chk(!prev_valid, "R6 pulse width", 2, 1);
        chk(cs_n, "R6 strobe while deselected", int'(cs_n), 1);
        chk(result == code, "R5 result code", int'(result), int'(code));
        chk(rchan == cmd[1], "R6 chan tag", int'(rchan), int'(cmd[1]));
        chk(rdiff == !cmd[2], "R6 diff tag", int'(rdiff), int'(!cmd[2]));
        last_chan = rchan; last_diff = rdiff;
      end
      prev_valid = rvalid;

      if (!cs_n && prev_cs) begin
        if (seen) begin
          chk(hi_cnt >= GAP, "R8 deselect time", hi_cnt, GAP);
          last_gap = hi_cnt;
        end
        seen = 1'b1; rises = 0; since_fall = 0; run = 0;
        tail_bad = 1'b0; moved = 1'b0; cmd = '0;
      end
      if (cs_n && !prev_cs) begin
        chk(rises == 16, "R3 rising edges per frame", rises, 16);
        chk(cmd[3] && cmd[0], "R4 start and order bits", int'(cmd), 9);
        chk(!tail_bad, "R4 data-in zero after command", 1, 0);
        chk(!moved, "R2 data-in steady while clock high", 1, 0);
        miso <= 1'b0;
      end
      if (cs_n) hi_cnt = prev_cs ? hi_cnt + 1 : 1;

      if (!cs_n && !prev_cs) begin
        if (sclk && prev_sclk && mosi != prev_mosi) moved = 1'b1;
        if (sclk && !prev_sclk) begin
          if (rises == 0) chk(since_fall >= SETUP, "R7 select setup", since_fall, SETUP);
          chk(run >= HALF, "R3 low time", run, HALF);
          rises++;
          if (rises <= 4) cmd[4-rises] = mosi;
          else if (mosi) tail_bad = 1'b1;
          if (rises == 4) begin
            int v;
            v = fno * STEP + int'({cmd[2], cmd[1]}) * OFF;
            code = v[9:0];
            fno++;
          end
          run = 1;
        end else if (!sclk && prev_sclk) begin
          if (rises > 0) chk(run >= HALF, "R3 high time", run, HALF);
          // null bit forced to 1 so that a failure to drop it shows
          if (rises == 4) miso <= 1'b1;
          else if (rises >= 5 && rises <= 14) miso <= code[14-rises];
          else miso <= 1'b0;
          run = 1;
        end else begin
          run++;
        end
      end else if (!cs_n) begin
        run = 1;
      end
      if (!cs_n) since_fall++;
      prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
    end
  end
endmodule

// File: tb/spi_adc_seq_tb_top.sv
module spi_adc_seq_tb_top;
  localparam int HALF  = 2;
  localparam int SETUP = 3;
  localparam int GAP   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, chan = 1'b0, diff = 1'b0, cont = 1'b0;

  logic       busy0, cs0, sclk0, mosi0, miso0, rc0, rd0, rv0;
  logic       busy3, cs3, sclk3, mosi3, miso3, rc3, rd3, rv3;
  logic [9:0] res0, res3;

  int t_checks = 0, t_fails = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_adc_seq #(.HALF_CYC(HALF), .CS_SETUP_CYC(SETUP), .CS_HIGH_CYC(GAP), .CLK_POL(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .diff_i(diff),
    .cont_i(cont), .busy_o(busy0), .cs_no(cs0), .sclk_o(sclk0), .mosi_o(mosi0),
    .miso_i(miso0), .result_o(res0), .result_chan_o(rc0), .result_diff_o(rd0),
    .result_valid_o(rv0));

  spi_adc_seq #(.HALF_CYC(HALF), .CS_SETUP_CYC(SETUP), .CS_HIGH_CYC(GAP), .CLK_POL(1)) dut_m3_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .diff_i(diff),
    .cont_i(cont), .busy_o(busy3), .cs_no(cs3), .sclk_o(sclk3), .mosi_o(mosi3),
    .miso_i(miso3), .result_o(res3), .result_chan_o(rc3), .result_diff_o(rd3),
    .result_valid_o(rv3));

  spi_adc_seq_tb_side #(.CPOL(0), .HALF(HALF), .SETUP(SETUP), .GAP(GAP)) w0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs0), .sclk(sclk0), .mosi(mosi0), .miso(miso0),
    .result(res0), .rchan(rc0), .rdiff(rd0), .rvalid(rv0));

  spi_adc_seq_tb_side #(.CPOL(1), .HALF(HALF), .SETUP(SETUP), .GAP(GAP)) w3 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs3), .sclk(sclk3), .mosi(mosi3), .miso(miso3),
    .result(res3), .rchan(rc3), .rdiff(rd3), .rvalid(rv3));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    t_checks++;
    if (!ok) begin
      t_fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d",
             t_checks + w0.checks + w3.checks, t_fails + w0.fails + w3.fails);
    $finish;
  endtask

  task automatic pulse_start(input logic c, input logic d);
    @(negedge clk);
    chan = c; diff = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valids(input int n);
    int target;
    target = w0.nvalid + n;
    while (w0.nvalid < target || w3.nvalid < target) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      t_checks++; t_fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 180000);
      report();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cs0 && cs3, "R1 chip select high", int'(cs0 & cs3), 1);
    chk(sclk0 == 1'b0, "R1 mode0 clock idle", int'(sclk0), 0);
    chk(sclk3 == 1'b1, "R1 mode3 clock idle", int'(sclk3), 1);
    chk(!rv0 && !rv3, "R1 no strobe", int'(rv0 | rv3), 0);
    chk(!busy0 && !busy3, "R1 not busy", int'(busy0 | busy3), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R6: every command combination as single shots
    for (int k = 0; k < 4; k++) begin
      pulse_start(k[0], k[1]);
      chk(busy0 && busy3, "R1 busy during frame", int'(busy0 & busy3), 1);
      wait_valids(1);
      chk(w0.last_chan == k[0] && w3.last_chan == k[0], "R6 chan tag", int'(w0.last_chan), k & 1);
      chk(w0.last_diff == k[1] && w3.last_diff == k[1], "R6 diff tag", int'(w0.last_diff), (k >> 1) & 1);
    end
    repeat (20) @(negedge clk);

    // R9: second start mid-frame is held and launched at end of deselect
    pulse_start(1'b0, 1'b0);
    repeat (20) @(negedge clk);
    pulse_start(1'b1, 1'b1);
    wait_valids(1);
    chk(w0.last_chan == 1'b0 && w0.last_diff == 1'b0, "R9 first request tags",
        int'({w0.last_chan, w0.last_diff}), 0);
    wait_valids(1);
    chk(w0.last_chan && w0.last_diff && w3.last_chan && w3.last_diff, "R9 held request tags",
        int'({w0.last_chan, w0.last_diff}), 3);
    chk(w0.last_gap == GAP, "R9 launch at deselect end mode0", w0.last_gap, GAP);
    chk(w3.last_gap == GAP, "R9 launch at deselect end mode3", w3.last_gap, GAP);

    // R10 R5: continuous sweep over all codes with the held command
    @(negedge clk);
    cont = 1'b1;
    wait_valids(1024);
    chk(w0.last_gap == GAP && w3.last_gap == GAP, "R10 back-to-back gap", w0.last_gap, GAP);
    chk(w0.last_chan && w0.last_diff, "R10 repeated command", int'({w0.last_chan, w0.last_diff}), 3);
    cont = 1'b0;
    while (busy0 || busy3) @(negedge clk);
    begin
      int n0;
      n0 = w0.nvalid;
      repeat (100) @(negedge clk);
      chk(w0.nvalid == n0 && cs0 && cs3, "R10 stops after cont drops", w0.nvalid, n0);
    end
    // R2: idle level by mode after traffic
    chk(sclk0 == 1'b0 && sclk3 == 1'b1, "R2 idle clock level",
        int'({sclk0, sclk3}), 1);
    chk(w0.nvalid >= 1030, "R5 sweep frame count", w0.nvalid, 1030);

    done = 1'b1;
    report();
  end
endmodule